// File: doc/BRIEF.md
# Edge-Triggered Interrupt Controller

This block gathers eleven interrupt request lines from peripheral units and gives the processor a single combined request. Each line is held at a level by its source. The controller keeps a registered copy of each line's level from the previous cycle. It records a pending flag for a source only on the cycle where that line goes from low to high. A line that stays high therefore produces one pending event and no more, however long it stays high.

Software reaches two 32-bit registers through a simple register port. The pending-status register is acknowledged by writing zeros: the written value is ANDed into the register. The enable mask register selects which pending flags may reach the processor. Pending flags are recorded whether or not their source is enabled, so a source that is unmasked later still shows its earlier event. The processor request is high whenever a pending flag is also enabled.

Source index map: 0 vertical blank, 1 graphics, 2 optical drive, 3 DMA, 4 to 6 timers 0 to 2, 7 controller port, 8 serial port, 9 sound, 10 light pen / parallel port.

Top module: `irqc_top`

## Requirements
- R1: While reset is low and after it is released, the pending-status register (offset 0x00) and the enable mask register (offset 0x04) both read 0, and `cpu_irq` is low.
- R2: A low-to-high transition of `irq_lines[i]`, seen at a clock edge, sets bit i of the pending-status register after that edge.
- R3: A line that stays high after its pending bit was cleared does not set the bit again. Only a new low-to-high transition sets it again.
- R4: A rising edge sets the pending bit even while its mask bit is 0. Enabling the mask bit afterwards raises `cpu_irq` without a new edge.
- R5: A write to offset 0x00 replaces the pending-status register with (status AND write data). A 0 in bit i clears bit i, and a 1 leaves it as it was.
- R6: A write to offset 0x04 loads write-data bits 10:0 into the mask. Reads of either register return the 11-bit value in bits 10:0, with bits 31:11 set to zero.
- R7: `cpu_irq` is high exactly when some bit is set in both the pending-status register and the mask. It follows each edge, status write or mask write from the clock edge that updates the register.
- R8: When a rising edge and a status write with a 0 for the same bit happen in the same cycle, the bit ends up set.
- R9: Offsets other than 0x00 and 0x04 read as 0. Writes to them change neither register.
- R10: Reset clears the stored previous line levels. A line that is high when reset is released is counted as a rising edge on the first clock edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_lines | input | 11 | Level request lines from the sources, synchronous to clk |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the register at reg_addr (combinational) |
| cpu_irq | output | 1 | Combined request to the processor |

## Verification
The assertions take for granted that the request lines and the register-port signals are synchronous to the clock and stable around each rising edge, because edge detection compares just two samples. They also assume that `reg_wr` is valid only with a settled address, so that a write hits exactly one register. The bench drives every input on the falling clock edge and holds it for a full cycle. It samples outputs on the falling edge after the rising edge that should update them, so each line transition and each write is seen by exactly one active edge.

// File: rtl/irqc_pkg.sv
// Package: shared constants for the edge-triggered interrupt controller.
// Assumes byte offsets on the register port and 32-bit register data.
package irqc_pkg;
    localparam int IRQC_NUM_SRC = 11;
    localparam int IRQC_ADDR_W  = 8;
    localparam int IRQC_DATA_W  = 32;
    localparam int IRQC_STATUS_OFS = 'h00;
    localparam int IRQC_MASK_OFS   = 'h04;

    // Source index assignment (fixed by the peripheral wiring)
    typedef enum int {
        SRC_VBLANK = 0, SRC_GFX = 1, SRC_DRIVE = 2, SRC_DMA = 3,
        SRC_TMR0 = 4, SRC_TMR1 = 5, SRC_TMR2 = 6, SRC_PORT = 7,
        SRC_SERIAL = 8, SRC_SOUND = 9, SRC_LPEN = 10
    } irqc_src_e;
endpackage

// File: rtl/irqc_edge_detect.sv
// Module: per-line rising-edge detector.
// Keeps each line's level from the previous cycle and flags a 0-to-1 change.
// Assumes the lines are already synchronous to clk; reset clears the history.
module irqc_edge_detect #(
    parameter int NUM_SRC = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] lines,
    output logic [NUM_SRC-1:0] line_prev,
    output logic [NUM_SRC-1:0] rise
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_line
        // Record the level of line g for the next cycle's compare
        always_ff @(posedge clk) begin
            if (!rst_n) line_prev[g] <= 1'b0;
            else        line_prev[g] <= lines[g];
        end
        // Flag a rising transition on line g
        assign rise[g] = lines[g] & ~line_prev[g];
    end
endmodule

// File: rtl/irqc_status_reg.sv
// Module: pending-status register.
// Sets bits on detected edges; a write ANDs the data in (zero acknowledges).
// An edge in the same cycle as a clearing write wins.
module irqc_status_reg #(
    parameter int NUM_SRC = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] rise,
    input  logic               wr_en,
    input  logic [NUM_SRC-1:0] wr_data,
    output logic [NUM_SRC-1:0] status_q
);
    logic [NUM_SRC-1:0] kept;

    // Apply the acknowledge mask only when a status write is present
    always_comb begin
        kept = wr_en ? (status_q & wr_data) : status_q;
    end

    // Update pending flags, edges ORed in after the acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= kept | rise;
    end
endmodule

// File: rtl/irqc_mask_reg.sv
// Module: enable mask register, loaded by a full write of its low bits.
// Resets to all sources disabled.
module irqc_mask_reg #(
    parameter int NUM_SRC = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [NUM_SRC-1:0] wr_data,
    output logic [NUM_SRC-1:0] mask_q
);
    // Hold or load the enable bits
    always_ff @(posedge clk) begin
        if (!rst_n)     mask_q <= '0;
        else if (wr_en) mask_q <= wr_data;
    end
endmodule

// File: rtl/irqc_top.sv
// Module: edge-triggered interrupt controller top.
// Combines edge detection, pending status, enable mask, register decode and
// the processor request. Assumes lines and register port are synchronous to clk.
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = IRQC_NUM_SRC,
    parameter int ADDR_W  = IRQC_ADDR_W,
    parameter int DATA_W  = IRQC_DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_lines,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               cpu_irq
);
    localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(IRQC_STATUS_OFS);
    localparam logic [ADDR_W-1:0] MASK_ADDR   = ADDR_W'(IRQC_MASK_OFS);

    logic [NUM_SRC-1:0] line_prev;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] mask_q;
    logic               sel_status;
    logic               sel_mask;
    logic               unused_wdata_hi;

    assign sel_status = (reg_addr == STATUS_ADDR);
    assign sel_mask   = (reg_addr == MASK_ADDR);
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_SRC];

    irqc_edge_detect #(.NUM_SRC(NUM_SRC)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .lines     (irq_lines),
        .line_prev (line_prev),
        .rise      (rise)
    );

    irqc_status_reg #(.NUM_SRC(NUM_SRC)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .wr_en    (reg_wr & sel_status),
        .wr_data  (reg_wdata[NUM_SRC-1:0]),
        .status_q (status_q)
    );

    irqc_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr & sel_mask),
        .wr_data (reg_wdata[NUM_SRC-1:0]),
        .mask_q  (mask_q)
    );

    // Read mux: selected register zero-extended, anything else reads zero
    always_comb begin
        reg_rdata = '0;
        if (sel_status)    reg_rdata = DATA_W'(status_q);
        else if (sel_mask) reg_rdata = DATA_W'(mask_q);
    end

    // Processor request: any enabled pending source
    assign cpu_irq = |(status_q & mask_q);
endmodule

// File: rtl/irqc_checker.sv
// Module: assertion checker for irqc_top, attached by bind.
// Assumes inputs change only between clock edges.
module irqc_checker #(
    parameter int NUM_SRC = 11,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_lines,
    input logic [NUM_SRC-1:0] line_prev,
    input logic [NUM_SRC-1:0] status_q,
    input logic [NUM_SRC-1:0] mask_q,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [DATA_W-1:0]  reg_rdata,
    input logic               cpu_irq
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
        AST_EDGE_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_lines[g] && !line_prev[g]) |=> status_q[g]); // R2
        AST_SET_ONLY_BY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status_q[g]) |-> $past(irq_lines[g] && !line_prev[g])); // R3
        AST_ZERO_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == ADDR_W'(0) && !reg_wdata[g] && !(irq_lines[g] && !line_prev[g]))
            |=> !status_q[g]); // R5
    end

    AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(4)) |=> (mask_q == $past(reg_wdata[NUM_SRC-1:0]))); // R6
    AST_READ_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:NUM_SRC] == '0); // R6
    AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !cpu_irq); // R7
    AST_UNUSED_WRITE_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr != ADDR_W'(4)) |=> $stable(mask_q)); // R9
endmodule

bind irqc_top irqc_checker #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lines (irq_lines),
    .line_prev (line_prev),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cpu_irq   (cpu_irq)
);

// File: tb/tb_irqc_top.sv
// Bench: directed scenarios for irqc_top, one task each, self-checking.
module tb_irqc_top;
    localparam int NS = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] irq_lines = '0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_addr = 8'h00;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          cpu_irq;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    irqc_top dut (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_irq(cpu_irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One clock: from a falling edge to the next falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic expect_reg(input logic [7:0] a, input logic [31:0] e, input string req);
        logic [31:0] v;
        rd(a, v);
        check(v === e, req, v, e);
    endtask

    task automatic t_reset();
        expect_reg(8'h00, 32'h0, "R1 status after reset");
        expect_reg(8'h04, 32'h0, "R1 mask after reset");
        check(cpu_irq === 1'b0, "R1 irq after reset", 32'(cpu_irq), 32'h0);
    endtask

    task automatic t_each_line();
        for (int i = 0; i < NS; i++) begin
            irq_lines[i] = 1'b1; tick();
            irq_lines[i] = 1'b0; tick();
            expect_reg(8'h00, 32'(1) << i, "R2 pulse sets own bit");
            check(cpu_irq === 1'b0, "R4 masked pending gives no irq", 32'(cpu_irq), 32'h0);
            wr(8'h00, 32'h0);
            expect_reg(8'h00, 32'h0, "R5 zero write clears");
        end
    endtask

    task automatic t_masked_keep();
        irq_lines[3] = 1'b1; tick(); irq_lines[3] = 1'b0; tick();
        check(cpu_irq === 1'b0, "R4 irq low while masked", 32'(cpu_irq), 32'h0);
        wr(8'h04, 32'h8);
        check(cpu_irq === 1'b1, "R4 unmask raises irq", 32'(cpu_irq), 32'h1);
        wr(8'h00, 32'hFFFF_FFFF);
        expect_reg(8'h00, 32'h8, "R5 one write keeps bit");
        wr(8'h00, 32'hFFFF_FFF7);
        expect_reg(8'h00, 32'h0, "R5 selective clear");
        check(cpu_irq === 1'b0, "R7 irq drops after ack", 32'(cpu_irq), 32'h0);
        wr(8'h04, 32'h0);
    endtask

    task automatic t_held_high();
        irq_lines[5] = 1'b1; tick();
        expect_reg(8'h00, 32'h20, "R2 edge on held line");
        wr(8'h00, 32'h0);
        tick(); tick(); tick();
        expect_reg(8'h00, 32'h0, "R3 held line no re-set");
        irq_lines[5] = 1'b0; tick();
        irq_lines[5] = 1'b1; tick();
        expect_reg(8'h00, 32'h20, "R3 new edge sets again");
        irq_lines[5] = 1'b0;
        wr(8'h00, 32'h0);
    endtask

    task automatic t_irq_combine();
        irq_lines[1] = 1'b1; irq_lines[6] = 1'b1; tick();
        irq_lines = '0; tick();
        wr(8'h04, 32'h200);
        check(cpu_irq === 1'b0, "R7 disjoint mask no irq", 32'(cpu_irq), 32'h0);
        wr(8'h04, 32'h240);
        check(cpu_irq === 1'b1, "R7 overlap raises irq", 32'(cpu_irq), 32'h1);
        wr(8'h00, 32'h002);
        check(cpu_irq === 1'b0, "R7 clearing enabled bit drops irq", 32'(cpu_irq), 32'h0);
        expect_reg(8'h00, 32'h002, "R5 other bit kept");
        irq_lines[9] = 1'b1; tick();
        check(cpu_irq === 1'b1, "R7 edge on enabled source", 32'(cpu_irq), 32'h1);
        irq_lines[9] = 1'b0;
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h0);
    endtask

    task automatic t_simultaneous();
        irq_lines[2] = 1'b1;
        reg_wr = 1'b1; reg_addr = 8'h00; reg_wdata = 32'h0;
        tick();
        reg_wr = 1'b0; irq_lines[2] = 1'b0;
        expect_reg(8'h00, 32'h4, "R8 edge beats clear");
        wr(8'h00, 32'h0);
    endtask

    task automatic t_mask_rw();
        wr(8'h04, 32'hFFFF_FFFF);
        expect_reg(8'h04, 32'h7FF, "R6 mask low bits only");
        wr(8'h04, 32'h0000_0555);
        expect_reg(8'h04, 32'h555, "R6 mask pattern");
    endtask

    task automatic t_unused();
        irq_lines[0] = 1'b1; tick(); irq_lines[0] = 1'b0; tick();
        wr(8'h08, 32'h0);
        wr(8'h01, 32'h0);
        expect_reg(8'h08, 32'h0, "R9 unused offset reads zero");
        expect_reg(8'h00, 32'h1, "R9 status untouched");
        expect_reg(8'h04, 32'h555, "R9 mask untouched");
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h0);
    endtask

    task automatic t_reset_high();
        rst_n = 1'b0; irq_lines[0] = 1'b1;
        tick(); tick();
        expect_reg(8'h00, 32'h0, "R1 status held in reset");
        rst_n = 1'b1; tick();
        expect_reg(8'h00, 32'h1, "R10 high line at release counts");
        irq_lines[0] = 1'b0;
    endtask

    initial begin
        tick(); tick();
        t_reset();
        rst_n = 1'b1; tick();
        t_reset();
        t_each_line();
        t_masked_keep();
        t_held_high();
        t_irq_combine();
        t_simultaneous();
        t_mask_rw();
        t_unused();
        t_reset_high();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule